// File: doc/BRIEF.md
# Bit-Serial One-Bit Processor Core

This core executes a tiny instruction set in which every datum is a single bit. Its whole state is a one-bit accumulator and two 16-bit pointers. One pointer walks forward through a stream of three-bit opcodes. The other walks backward through a stream of sixteen-bit operands. All traffic to the external memory of 65536 one-bit cells goes through a single bit-wide port. That port carries one address, one read bit, one write bit and a write strobe.

Every instruction takes exactly twenty clock cycles:
- three cycles fetch the opcode bits;
- sixteen cycles fetch the operand bits;
- one execute cycle loads, stores or combines the accumulator, and both pointers step or jump.

The memory read is combinational: the bit at the presented address must be valid in the same cycle.

A halt input freezes the core for test. While halt is held, a step pulse lets exactly one cycle proceed.

Top module: `bit_serial_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the accumulator and both pointers are zero, the address output is 0 and the write strobe is low.
- R2: The first three cycles of an instruction present the opcode pointer, then the pointer plus 1, then the pointer plus 2. The bit read at the pointer is opcode bit 0 (the least significant bit).
- R3: The next sixteen cycles present the operand pointer minus 1 down to the operand pointer minus 16, modulo 2^16. The bit read at the pointer minus 1 is operand bit 0, and the last bit read is bit 15.
- R4: Every instruction lasts 20 cycles. Unless a jump is taken, the opcode pointer then advances by 3 and the operand pointer drops by 16, both modulo 2^16.
- R5: Opcode 001 copies into the accumulator the memory bit at the operand address. That address is presented in the execute (20th) cycle.
- R6: Opcode 010 presents the operand address in the execute cycle and drives the write strobe high for that one cycle only, with the write bit equal to the accumulator. No other opcode raises the strobe.
- R7: Opcode 011 loads the opcode pointer with the operand when the accumulator is 0, and the operand pointer still drops by 16. When the accumulator is 1, both pointers step normally.
- R8: Opcode 100 loads the operand pointer with the operand when the accumulator is 0, and the opcode pointer still advances by 3. When the accumulator is 1, both pointers step normally.
- R9: Opcodes 101, 110 and 111 set the accumulator to its AND, OR and XOR, respectively, with operand bit 0. All other operand bits are ignored.
- R10: Opcode 000 leaves the accumulator unchanged and only steps the pointers.
- R11: While halt is high and step is low, the address, the accumulator and both pointers hold, and the write strobe stays low. A cycle with step high advances the core by exactly one cycle, including a pending store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | Freeze the core while high |
| step_i | input | 1 | While halted, let the current cycle proceed |
| mem_addr_o | output | 16 | Memory bit address |
| mem_rdata_i | input | 1 | Memory bit at mem_addr_o, same cycle |
| mem_wdata_o | output | 1 | Bit to store |
| mem_we_o | output | 1 | Write strobe |

## Verification
Two things can happen in the same execute cycle. A taken jump loads one pointer while the other pointer still takes its normal step. The bench provokes this with an opcode-pointer jump and an operand-pointer jump taken from a zero accumulator. Each is followed by the same jumps with the accumulator set to one. The outcome is judged at the ports by tracing the full address sequence of the next instruction: its three opcode addresses show one pointer and its sixteen operand addresses show the other. A second collision, a store whose execute cycle meets a halt, is provoked by single-stepping a store. The strobe must stay low until the step cycle and rise only within it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 3'b000,
        OP_LOAD  = 3'b001,
        OP_STORE = 3'b010,
        OP_JMPC  = 3'b011,
        OP_JMPD  = 3'b100,
        OP_AND   = 3'b101,
        OP_OR    = 3'b110,
        OP_XOR   = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_OPR  = 2'd1,
        PH_EXEC = 2'd2
    } phase_e;

endpackage

// File: rtl/bsc_sequencer.sv
module bsc_sequencer #(
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(ADDR_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    output bsc_pkg::phase_e   kind_o,
    output logic [IDX_W-1:0]  idx_o
);
    import bsc_pkg::*;

    localparam logic [IDX_W-1:0] OPC_LAST = IDX_W'(OPC_W - 1);
    localparam logic [IDX_W-1:0] OPR_LAST = IDX_W'(ADDR_W - 1);

    typedef struct packed {
        phase_e           kind;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (adv_i) begin
            unique case (seq_q.kind)
                PH_OPC: begin
                    if (seq_q.idx == OPC_LAST) begin
                        seq_d.kind = PH_OPR;
                        seq_d.idx  = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
                PH_OPR: begin
                    if (seq_q.idx == OPR_LAST) begin
                        seq_d.kind = PH_EXEC;
                        seq_d.idx  = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
                default: begin
                    seq_d.kind = PH_OPC;
                    seq_d.idx  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q.kind <= PH_OPC;
            seq_q.idx  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign kind_o = seq_q.kind;
    assign idx_o  = seq_q.idx;

    // R2: the opcode phase never indexes past the third bit
    a_r2_opc_idx_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (seq_q.kind == PH_OPC) |-> (seq_q.idx <= OPC_LAST));

    // R4: the execute cycle is a single cycle and is followed by a fresh fetch
    a_r4_exec_single: assert property (@(posedge clk_i) disable iff (rst_i)
        (seq_q.kind == PH_EXEC && adv_i) |=> (seq_q.kind == PH_OPC && seq_q.idx == '0));

    // R3: the operand phase hands over to execute only after its last bit
    a_r3_opr_to_exec: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(seq_q.kind == PH_EXEC)) |-> ($past(seq_q.idx) == OPR_LAST));

    // R11: no phase movement without advance
    a_r11_seq_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!adv_i) |=> ($stable(seq_q.kind) && $stable(seq_q.idx)));

endmodule

// File: rtl/bsc_regs.sv
module bsc_regs #(
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(ADDR_W)
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          adv_i,
    input  bsc_pkg::phase_e               kind_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic                          rdata_i,
    output logic                          acc_o,
    output logic [ADDR_W-1:0]             p3_o,
    output logic [ADDR_W-1:0]             p16_o,
    output bsc_pkg::op_e                  opc_o,
    output logic [ADDR_W-1:0]             opr_o
);
    import bsc_pkg::*;

    localparam logic [ADDR_W-1:0] P3_STEP  = ADDR_W'(OPC_W);
    localparam logic [ADDR_W-1:0] P16_STEP = ADDR_W'(ADDR_W);

    typedef struct packed {
        logic              acc;
        logic              lbit;
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] opr;
        logic [ADDR_W-1:0] p3;
        logic [ADDR_W-1:0] p16;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            unique case (kind_i)
                PH_OPC: begin
                    for (int k = 0; k < OPC_W; k++) begin
                        if (idx_i == IDX_W'(k)) st_d.opc[k] = rdata_i;
                    end
                end
                PH_OPR: begin
                    for (int k = 0; k < ADDR_W; k++) begin
                        if (idx_i == IDX_W'(k)) st_d.opr[k] = rdata_i;
                    end
                    if (idx_i == '0) st_d.lbit = rdata_i;
                end
                default: begin
                    st_d.p3  = st_q.p3 + P3_STEP;
                    st_d.p16 = st_q.p16 - P16_STEP;
                    case (op_e'(st_q.opc))
                        OP_LOAD: st_d.acc = rdata_i;
                        OP_JMPC: if (!st_q.acc) st_d.p3  = st_q.opr;
                        OP_JMPD: if (!st_q.acc) st_d.p16 = st_q.opr;
                        OP_AND:  st_d.acc = st_q.acc & st_q.lbit;
                        OP_OR:   st_d.acc = st_q.acc | st_q.lbit;
                        OP_XOR:  st_d.acc = st_q.acc ^ st_q.lbit;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
    assign p3_o  = st_q.p3;
    assign p16_o = st_q.p16;
    assign opc_o = op_e'(st_q.opc);
    assign opr_o = st_q.opr;

    // R4: pointers only move in an advancing execute cycle
    a_r4_ptr_only_exec: assert property (@(posedge clk_i) disable iff (rst_i)
        !(kind_i == PH_EXEC && adv_i) |=> ($stable(st_q.p3) && $stable(st_q.p16)));

    // R4: non-jump opcodes step both pointers
    a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (kind_i == PH_EXEC && adv_i && st_q.opc != OP_JMPC && st_q.opc != OP_JMPD)
        |=> (st_q.p3 == $past(st_q.p3) + P3_STEP && st_q.p16 == $past(st_q.p16) - P16_STEP));

    // R7: taken opcode-pointer jump, operand pointer still steps
    a_r7_jmpc_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        (kind_i == PH_EXEC && adv_i && st_q.opc == OP_JMPC && !st_q.acc)
        |=> (st_q.p3 == $past(st_q.opr) && st_q.p16 == $past(st_q.p16) - P16_STEP));

    // R8: taken operand-pointer jump, opcode pointer still steps
    a_r8_jmpd_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        (kind_i == PH_EXEC && adv_i && st_q.opc == OP_JMPD && !st_q.acc)
        |=> (st_q.p16 == $past(st_q.opr) && st_q.p3 == $past(st_q.p3) + P3_STEP));

    // R10: the accumulator changes only in execute cycles
    a_r10_acc_only_exec: assert property (@(posedge clk_i) disable iff (rst_i)
        !(kind_i == PH_EXEC && adv_i) |=> $stable(st_q.acc));

    // R11: frozen state while halted
    a_r11_regs_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!adv_i) |=> ($stable(st_q.acc) && $stable(st_q.opc) && $stable(st_q.opr)));

endmodule

// File: rtl/bsc_addr_gen.sv
module bsc_addr_gen #(
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(ADDR_W)
) (
    input  bsc_pkg::phase_e     kind_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [ADDR_W-1:0]   p3_i,
    input  logic [ADDR_W-1:0]   p16_i,
    input  logic [ADDR_W-1:0]   opr_i,
    output logic [ADDR_W-1:0]   addr_o
);
    import bsc_pkg::*;

    logic [ADDR_W-1:0] idx_ext;

    always_comb begin
        idx_ext = ADDR_W'(idx_i);
        unique case (kind_i)
            PH_OPC:  addr_o = p3_i + idx_ext;
            PH_OPR:  addr_o = p16_i - ADDR_W'(1) - idx_ext;
            default: addr_o = opr_i;
        endcase
    end

endmodule

// File: rtl/bit_serial_core.sv
module bit_serial_core #(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              halt_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rdata_i,
    output logic              mem_wdata_o,
    output logic              mem_we_o
);
    import bsc_pkg::*;

    localparam int IDX_W = $clog2(ADDR_W);

    logic              adv;
    phase_e            kind;
    logic [IDX_W-1:0]  idx;
    logic              acc;
    logic [ADDR_W-1:0] p3;
    logic [ADDR_W-1:0] p16;
    op_e               opc;
    logic [ADDR_W-1:0] opr;

    assign adv = !halt_i || step_i;

    bsc_sequencer #(.ADDR_W(ADDR_W)) i_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (adv),
        .kind_o (kind),
        .idx_o  (idx)
    );

    bsc_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (adv),
        .kind_i  (kind),
        .idx_i   (idx),
        .rdata_i (mem_rdata_i),
        .acc_o   (acc),
        .p3_o    (p3),
        .p16_o   (p16),
        .opc_o   (opc),
        .opr_o   (opr)
    );

    bsc_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .kind_i (kind),
        .idx_i  (idx),
        .p3_i   (p3),
        .p16_i  (p16),
        .opr_i  (opr),
        .addr_o (mem_addr_o)
    );

    assign mem_wdata_o = acc;
    assign mem_we_o    = (kind == PH_EXEC) && (opc == OP_STORE) && adv;

    // R1: first cycle after reset fetches from address zero without writing
    a_r1_reset_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (mem_addr_o == '0 && !mem_we_o));

    // R6: a store strobe never lasts two cycles
    a_r6_we_single: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we_o |=> !mem_we_o);

    // R6: the strobe is raised only for a store opcode
    a_r6_we_store_only: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we_o |-> (opc == OP_STORE && mem_addr_o == opr));

    // R11: no write while frozen
    a_r11_no_we_halted: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_i && !step_i) |-> !mem_we_o);

    // R11: the address holds across a frozen cycle
    a_r11_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_i && !step_i) |=> $stable(mem_addr_o));

endmodule

// File: tb/test_bit_serial_core.sv
module test_bit_serial_core;

    logic        clk;
    logic        rst;
    logic        halt;
    logic        step;
    logic [15:0] mem_addr;
    logic        mem_rdata;
    logic        mem_wdata;
    logic        mem_we;

    logic        mem [0:1023];

    int n_chk;
    int n_fail;
    bit finished;

    // each row: {opcode[2:0], operand[15:0], expected store bit}
    localparam logic [19:0] PROG [18] = '{
        {3'b110, 16'h0001, 1'b0},
        {3'b010, 16'h0210, 1'b1},
        {3'b101, 16'hFFFE, 1'b0},
        {3'b010, 16'h0211, 1'b0},
        {3'b111, 16'h0003, 1'b0},
        {3'b010, 16'h0212, 1'b1},
        {3'b111, 16'h0001, 1'b0},
        {3'b010, 16'h0213, 1'b0},
        {3'b001, 16'h0200, 1'b0},
        {3'b010, 16'h0214, 1'b1},
        {3'b110, 16'h8000, 1'b0},
        {3'b101, 16'hFFFF, 1'b0},
        {3'b010, 16'h0215, 1'b1},
        {3'b001, 16'h0201, 1'b0},
        {3'b000, 16'h0200, 1'b0},
        {3'b010, 16'h0216, 1'b0},
        {3'b110, 16'h0000, 1'b0},
        {3'b010, 16'h0217, 1'b0}
    };

    bit_serial_core i_bit_serial_core (
        .clk_i       (clk),
        .rst_i       (rst),
        .halt_i      (halt),
        .step_i      (step),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 1024; k++) mem[k] = 1'b0;
    endtask

    task automatic put_instr(input logic [15:0] p3, input logic [15:0] p16,
                             input logic [2:0] opc, input logic [15:0] opr);
        logic [15:0] a;
        for (int k = 0; k < 3; k++) begin
            a = p3 + 16'(k);
            mem[a[9:0]] = opc[k];
        end
        for (int k = 0; k < 16; k++) begin
            a = p16 - 16'd1 - 16'(k);
            mem[a[9:0]] = opr[k];
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] p3, input logic [15:0] p16,
                                             input logic [15:0] opr, input int c);
        if (c < 3)  return p3 + 16'(c);
        if (c < 19) return p16 - 16'd1 - 16'(c - 3);
        return opr;
    endfunction

    function automatic string exec_tag(input logic [2:0] opc);
        case (opc)
            3'b001: return "R5";
            3'b010: return "R6";
            3'b011: return "R7";
            3'b100: return "R8";
            3'b000: return "R10";
            default: return "R9";
        endcase
    endfunction

    // walks one 20-cycle instruction, entered and left at negedge+1
    task automatic run_instr(input logic [15:0] p3, input logic [15:0] p16,
                             input logic [2:0] opc, input logic [15:0] opr,
                             input logic exp_wd, input string wd_tag);
        for (int c = 0; c < 20; c++) begin
            if (c < 3)
                chk("R2", "opcode fetch address", mem_addr, exp_addr(p3, p16, opr, c));
            else if (c < 19)
                chk("R3", "operand fetch address", mem_addr, exp_addr(p3, p16, opr, c));
            else
                chk(exec_tag(opc), "execute address", mem_addr, opr);
            chk("R6", "write strobe", mem_we, (c == 19 && opc == 3'b010));
            if (c == 19 && opc == 3'b010)
                chk(wd_tag, "stored accumulator bit", mem_wdata, exp_wd);
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1", "address in reset", mem_addr, 16'h0000);
        chk("R1", "strobe in reset", mem_we, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string prev_tag;
        logic [2:0]  opc;
        logic [15:0] opr;
        logic        wd;
        n_chk = 0;
        n_fail = 0;
        finished = 1'b0;
        rst  = 1'b1;
        halt = 1'b0;
        step = 1'b0;

        // ---- table: straight-line program from the reset state
        clear_mem();
        for (int i = 0; i < 18; i++)
            put_instr(16'(3 * i), 16'(0 - 16 * i), PROG[i][19:17], PROG[i][16:1]);
        mem[10'h200] = 1'b1;
        mem[10'h201] = 1'b0;
        do_reset();
        chk("R1", "first fetch after reset", mem_addr, 16'h0000);
        prev_tag = "R9";
        for (int i = 0; i < 18; i++) begin
            opc = PROG[i][19:17];
            opr = PROG[i][16:1];
            wd  = PROG[i][0];
            run_instr(16'(3 * i), 16'(0 - 16 * i), opc, opr, wd, prev_tag);
            prev_tag = exec_tag(opc);
        end
        // R4: after 18 instructions of 20 cycles the opcode pointer reads 54
        chk("R4", "opcode pointer after table", mem_addr, 16'd54);

        // ---- directed: jumps taken and not taken
        clear_mem();
        put_instr(16'd0,  16'h0000, 3'b011, 16'h0009);
        put_instr(16'd9,  16'hFFF0, 3'b100, 16'h0100);
        put_instr(16'd12, 16'h0100, 3'b110, 16'h0001);
        put_instr(16'd15, 16'h00F0, 3'b011, 16'h0000);
        put_instr(16'd18, 16'h00E0, 3'b100, 16'h0000);
        put_instr(16'd21, 16'h00D0, 3'b010, 16'h0300);
        do_reset();
        run_instr(16'd0, 16'h0000, 3'b011, 16'h0009, 1'b0, "R7");
        chk("R7", "taken jump of opcode pointer", mem_addr, 16'd9);
        run_instr(16'd9, 16'hFFF0, 3'b100, 16'h0100, 1'b0, "R8");
        chk("R8", "opcode pointer stepped beside operand jump", mem_addr, 16'd12);
        run_instr(16'd12, 16'h0100, 3'b110, 16'h0001, 1'b0, "R9");
        run_instr(16'd15, 16'h00F0, 3'b011, 16'h0000, 1'b0, "R7");
        chk("R7", "untaken jump steps opcode pointer", mem_addr, 16'd18);
        run_instr(16'd18, 16'h00E0, 3'b100, 16'h0000, 1'b0, "R8");
        run_instr(16'd21, 16'h00D0, 3'b010, 16'h0300, 1'b1, "R8");
        chk("R4", "opcode pointer after jump program", mem_addr, 16'd24);

        // ---- directed: halt and single step through a store
        clear_mem();
        put_instr(16'd0, 16'h0000, 3'b010, 16'h0300);
        halt = 1'b1;
        do_reset();
        for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            #1;
            chk("R11", "address frozen after reset", mem_addr, 16'h0000);
        end
        for (int c = 0; c < 20; c++) begin
            chk("R11", "stepped address", mem_addr, exp_addr(16'd0, 16'h0000, 16'h0300, c));
            @(negedge clk);
            #1;
            chk("R11", "held address without step", mem_addr,
                exp_addr(16'd0, 16'h0000, 16'h0300, c));
            chk("R11", "no strobe without step", mem_we, 1'b0);
            step = 1'b1;
            #1;
            chk("R11", "strobe during step", mem_we, (c == 19));
            @(negedge clk);
            step = 1'b0;
            #1;
        end
        chk("R11", "next opcode after stepped store", mem_addr, 16'd3);
        halt = 1'b0;

        finish_run();
    end

endmodule